// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is the slave side of a stereo audio serial link. An external bit clock and a word clock frame the traffic. The block sends one 20-bit capture sample pair per frame on a serial output. It also collects one playback sample pair per frame from a serial input and presents it as parallel words. A 2-bit format code chooses the alignment of each direction and the polarity of the word clock. Both directions carry two's-complement samples, most significant bit first.

The serial clocks are sampled by the block's own system clock `clk`. They pass through a short synchronizer and an edge detector, so the whole block runs in a single clock domain. A small state machine tracks the half-frames. It waits in `ST_IDLE` after reset until the first left half-frame starts (IDLE→LEFT). It then moves LEFT→RIGHT at each right half-frame start and RIGHT→LEFT at each left half-frame start. A left start seen in LEFT re-enters LEFT, which resynchronises the block. A slot counter restarts at every half-frame start, and all bit positions are taken from that counter.

Top module: `audio_serial_port`

## Requirements
- R1: Format codes are 0: playback right-aligned 20 bits; 1: playback right-aligned 16 bits; 2: playback right-aligned 24 bits; 3: I2S framing in both directions. In codes 0 to 2 the capture output is left-aligned 20 bits. The internal format register resets to 0 and is reloaded from `fmt` at every left half-frame start.
- R2: A half-frame starts on the first `bclk` falling edge at which `lrck` differs from its level at the previous falling edge. In codes 0 to 2, `lrck` high is left and low is right. In code 3, low is left and high is right. Slot numbers count from 0 at that edge.
- R3: In codes 0 to 2, slot k (k<20) of each half-frame carries capture bit 19−k of that channel's word.
- R4: In code 3, slot 0 carries 0 and slot k (1≤k≤20) carries capture bit 20−k.
- R5: `sdout` is 0 in every slot after the capture word, while idle, and after reset.
- R6: Both capture words are latched at each left half-frame start, and `cap_take` pulses for one `clk` cycle at that moment.
- R7: In codes 0 to 2, the playback word is the last N bits before the half-frame ends, with N = 20, 16 or 24. Earlier bits are ignored, and any half-frame of at least N slots works.
- R8: A 16-bit playback word comes out with four zero LSBs appended. A 24-bit word comes out as its upper 20 bits.
- R9: In code 3, playback bits are taken from slots 1 to 20 of each half-frame, MSB first.
- R10: `pb_valid` pulses for one cycle with both words once a right word arrives after a left word. In codes 0 to 2 this happens at the start of the next frame. In code 3 it happens at slot 20 of the right half-frame.
- R11: `sdout` changes after a `bclk` falling edge, within three `clk` cycles. `sdin` is taken at a `bclk` rising edge. Each `bclk` phase lasts at least four `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt | input | 2 | Format code, sampled at left half-frame starts |
| bclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Word clock selecting the channel |
| sdin | input | 1 | Serial playback data |
| sdout | output | 1 | Serial capture data |
| cap_left | input | 20 | Left capture sample |
| cap_right | input | 20 | Right capture sample |
| cap_take | output | 1 | Pulse when the capture pair is latched |
| pb_left | output | 20 | Left playback sample |
| pb_right | output | 20 | Right playback sample |
| pb_valid | output | 1 | Pulse when a new playback pair is presented |

## Verification
The bench sweeps every format code at half-frames of 24 and 32 slots and compares every serial slot and every playback pair against values it computes itself. Every slot ahead of a right-aligned word carries ones. A design that counted from the half-frame start instead of the end, or that missed the padding or truncation, would therefore produce wrong playback words. In I2S the capture word must start one slot late and the word clock polarity must flip. A design that got either wrong would emit shifted bits or swap channels. The 24-slot case sits exactly at the 24-bit minimum, so an off-by-one in the tail capture or in the zero fill after the capture word shows up as a wrong bit.

// File: rtl/asp_pkg.sv
`timescale 1ns/1ps
package asp_pkg;
    typedef enum logic [1:0] {
        FMT_RJ20 = 2'd0,
        FMT_RJ16 = 2'd1,
        FMT_RJ24 = 2'd2,
        FMT_I2S  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } half_e;
endpackage

// File: rtl/asp_sync.sv
`timescale 1ns/1ps
module asp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrck_i,
    input  logic sdin_i,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic lrck_s,
    output logic sdin_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][2:0] pipe_q;
    logic                   bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
            bclk_q <= 1'b0;
        end else begin
            pipe_q[0] <= {bclk_i, lrck_i, sdin_i};
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
            bclk_q <= pipe_q[LAST][2];
        end
    end

    assign bclk_rise = pipe_q[LAST][2] & ~bclk_q;
    assign bclk_fall = ~pipe_q[LAST][2] & bclk_q;
    assign lrck_s    = pipe_q[LAST][1];
    assign sdin_s    = pipe_q[LAST][0];
endmodule

// File: rtl/asp_tx.sv
`timescale 1ns/1ps
module asp_tx
    import asp_pkg::*;
#(
    parameter int WORD_W = 20,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic              active,
    input  logic              chan_left,
    input  logic [SLOT_W-1:0] slot,
    input  fmt_e              fmt,
    input  logic [WORD_W-1:0] word_l_i,
    input  logic [WORD_W-1:0] word_r_i,
    output logic              sdout
);
    localparam logic [SLOT_W-1:0] W_SL = SLOT_W'(WORD_W);

    logic [WORD_W-1:0] hold_l_q, hold_r_q, cur;
    logic [SLOT_W-1:0] pos;
    logic              in_word;
    logic              bit_d;

    always_comb begin
        cur     = load ? word_l_i : (chan_left ? hold_l_q : hold_r_q);
        pos     = (fmt == FMT_I2S) ? slot - 1'b1 : slot;
        in_word = (fmt != FMT_I2S || slot != '0) && (pos < W_SL);
        bit_d   = in_word ? cur[WORD_W-1-int'(pos)] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l_q <= '0;
            hold_r_q <= '0;
            sdout    <= 1'b0;
        end else begin
            if (load) begin
                hold_l_q <= word_l_i;
                hold_r_q <= word_r_i;
            end
            if (step) begin
                sdout <= active & bit_d;
            end
        end
    end

    a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && slot > W_SL) |=> !sdout);
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !active) |=> !sdout);
endmodule

// File: rtl/asp_rx.sv
`timescale 1ns/1ps
module asp_rx
    import asp_pkg::*;
#(
    parameter int WORD_W = 20,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              bit_i,
    input  logic              close,
    input  logic              active,
    input  logic              in_left,
    input  logic [SLOT_W-1:0] slot,
    input  fmt_e              fmt,
    output logic [WORD_W-1:0] pb_left,
    output logic [WORD_W-1:0] pb_right,
    output logic              pb_valid
);
    localparam int                SR_W = WORD_W + 4;
    localparam logic [SLOT_W-1:0] W_SL = SLOT_W'(WORD_W);

    logic [SR_W-1:0]   sr_q, sr_shift;
    logic [WORD_W-1:0] pend_l_q, tail_word, got_word;
    logic              have_l_q, i2s_grab, tail_grab, got;

    always_comb begin
        sr_shift = {sr_q[SR_W-2:0], bit_i};
        unique case (fmt)
            FMT_RJ16: tail_word = {sr_q[WORD_W-5:0], 4'b0000};
            FMT_RJ24: tail_word = sr_q[SR_W-1:4];
            default:  tail_word = sr_q[WORD_W-1:0];
        endcase
        i2s_grab  = sample && active && (fmt == FMT_I2S) && (slot == W_SL);
        tail_grab = close && active && (fmt != FMT_I2S);
        got       = i2s_grab | tail_grab;
        got_word  = i2s_grab ? sr_shift[WORD_W-1:0] : tail_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q     <= '0;
            pend_l_q <= '0;
            have_l_q <= 1'b0;
            pb_left  <= '0;
            pb_right <= '0;
            pb_valid <= 1'b0;
        end else begin
            pb_valid <= 1'b0;
            if (sample) begin
                sr_q <= sr_shift;
            end
            if (got) begin
                if (in_left) begin
                    pend_l_q <= got_word;
                    have_l_q <= 1'b1;
                end else begin
                    pb_valid <= have_l_q;
                    have_l_q <= 1'b0;
                    if (have_l_q) begin
                        pb_left  <= pend_l_q;
                        pb_right <= got_word;
                    end
                end
            end
        end
    end

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |=> !pb_valid);
    a_r10_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |-> $past(active && !in_left));
endmodule

// File: rtl/audio_serial_port.sv
`timescale 1ns/1ps
module audio_serial_port
    import asp_pkg::*;
#(
    parameter int WORD_W      = 20,
    parameter int SLOT_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt,
    input  logic              bclk,
    input  logic              lrck,
    input  logic              sdin,
    output logic              sdout,
    input  logic [WORD_W-1:0] cap_left,
    input  logic [WORD_W-1:0] cap_right,
    output logic              cap_take,
    output logic [WORD_W-1:0] pb_left,
    output logic [WORD_W-1:0] pb_right,
    output logic              pb_valid
);
    logic              bclk_rise, bclk_fall, lrck_s, sdin_s;
    logic              lrck_prev_q;
    half_e             state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    fmt_e              fmt_q, fmt_eff;
    logic              new_half, left_start;

    asp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk),
        .lrck_i    (lrck),
        .sdin_i    (sdin),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .lrck_s    (lrck_s),
        .sdin_s    (sdin_s)
    );

    // Half-frame boundary detection and next-state logic
    always_comb begin
        new_half   = bclk_fall && (lrck_s != lrck_prev_q);
        left_start = new_half && (lrck_s ^ (fmt_e'(fmt) == FMT_I2S));
        fmt_eff    = left_start ? fmt_e'(fmt) : fmt_q;
        state_d    = state_q;
        if (new_half) begin
            unique case (state_q)
                ST_IDLE:  state_d = left_start ? ST_LEFT : ST_IDLE;
                ST_LEFT:  state_d = left_start ? ST_LEFT : ST_RIGHT;
                ST_RIGHT: state_d = left_start ? ST_LEFT : ST_RIGHT;
                default:  state_d = ST_IDLE;
            endcase
        end
        if (new_half) begin
            slot_d = '0;
        end else if (bclk_fall && slot_q != '1) begin
            slot_d = slot_q + 1'b1;
        end else begin
            slot_d = slot_q;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            slot_q      <= '0;
            lrck_prev_q <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            if (bclk_fall) begin
                lrck_prev_q <= lrck_s;
            end
        end
    end

    // Registered outputs of the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q    <= FMT_RJ20;
            cap_take <= 1'b0;
        end else begin
            cap_take <= left_start;
            if (left_start) begin
                fmt_q <= fmt_e'(fmt);
            end
        end
    end

    asp_tx #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (bclk_fall),
        .load      (left_start),
        .active    (state_d != ST_IDLE),
        .chan_left (state_d == ST_LEFT),
        .slot      (slot_d),
        .fmt       (fmt_eff),
        .word_l_i  (cap_left),
        .word_r_i  (cap_right),
        .sdout     (sdout)
    );

    asp_rx #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (bclk_rise),
        .bit_i    (sdin_s),
        .close    (new_half),
        .active   (state_q != ST_IDLE),
        .in_left  (state_q == ST_LEFT),
        .slot     (slot_q),
        .fmt      (fmt_q),
        .pb_left  (pb_left),
        .pb_right (pb_right),
        .pb_valid (pb_valid)
    );

    a_r6_take_enters_left: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |-> (state_q == ST_LEFT));
    a_r6_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |=> !cap_take);
    a_r2_slot_restart: assert property (@(posedge clk) disable iff (!rst_n)
        new_half |=> (slot_q == '0));
endmodule

// File: tb/test_audio_serial_port.sv
`timescale 1ns/1ps
module test_audio_serial_port;
    logic        clk = 1'b0;
    logic        rst_n, bclk, lrck, sdin, sdout, cap_take, pb_valid;
    logic [1:0]  fmt;
    logic [19:0] cap_left, cap_right, pb_left, pb_right;
    logic [19:0] got_l, got_r;
    int          nchk = 0, nerr = 0, ntake = 0, nvalid = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    audio_serial_port i_audio_serial_port (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .bclk(bclk), .lrck(lrck),
        .sdin(sdin), .sdout(sdout), .cap_left(cap_left), .cap_right(cap_right),
        .cap_take(cap_take), .pb_left(pb_left), .pb_right(pb_right),
        .pb_valid(pb_valid)
    );

    always @(negedge clk) begin
        if (rst_n && pb_valid) begin
            nvalid++;
            got_l = pb_left;
            got_r = pb_right;
        end
        if (rst_n && cap_take) ntake++;
    end

    task automatic check(input bit ok, input string req,
                         input logic [39:0] act, input logic [39:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic in_bit(int mode, logic [23:0] w, int slot, int ns);
        int len, st;
        if (mode == 3) return (slot >= 1 && slot <= 20) ? w[20-slot] : 1'b1;
        len = (mode == 0) ? 20 : (mode == 1) ? 16 : 24;
        st  = ns - len;
        return (slot >= st) ? w[len-1-(slot-st)] : 1'b1;
    endfunction

    function automatic logic out_bit(int mode, logic [19:0] cw, int slot);
        if (mode == 3) return (slot >= 1 && slot <= 20) ? cw[20-slot] : 1'b0;
        return (slot < 20) ? cw[19-slot] : 1'b0;
    endfunction

    function automatic logic [19:0] exp_pb(int mode, logic [23:0] w);
        case (mode)
            1:       return {w[15:0], 4'h0};
            2:       return w[23:4];
            default: return w[19:0];
        endcase
    endfunction

    task automatic do_slot(input logic lr, input logic b, output logic s);
        @(negedge clk);
        bclk = 1'b0; lrck = lr; sdin = b;
        repeat (4) @(negedge clk);
        s = sdout;
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // One half-frame; the whole serial output is compared in one check
    task automatic do_half(input logic lr, input int mode, input int ns,
                           input logic [23:0] pw, input logic [19:0] cw);
        logic [31:0] gotv = '0, expv = '0;
        logic s;
        for (int k = 0; k < ns; k++) begin
            do_slot(lr, in_bit(mode, pw, k, ns), s);
            gotv[k] = s;
            expv[k] = out_bit(mode, cw, k);
        end
        check(gotv == expv, (mode == 3) ? "R4 R2 R5 R11 capture" : "R3 R2 R5 R11 capture",
              {8'h0, gotv}, {8'h0, expv});
    endtask

    initial begin
        logic [23:0] pl_a [4];
        logic [23:0] pr_a [4];
        logic        s;
        int          nt0, nv0, ns;
        string       preq;
        rst_n = 1'b0; bclk = 1'b1; lrck = 1'b0; sdin = 1'b0; fmt = 2'd0;
        cap_left = '0; cap_right = '0;
        for (int mode = 0; mode < 4; mode++) begin
            for (int k = 0; k < 2; k++) begin
                ns = k ? 32 : 24;
                preq = (mode == 0) ? "R7 R1 R10" : (mode == 3) ? "R9 R1 R10" : "R8 R7 R1 R10";
                rst_n = 1'b0; fmt = 2'(mode); bclk = 1'b1; lrck = (mode == 3);
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                repeat (4) @(negedge clk);
                // R5 R1: quiet outputs after reset
                check(!sdout && !pb_valid && !cap_take, "R5 R1 reset",
                      {37'h0, sdout, pb_valid, cap_take}, 40'h0);
                for (int p = 0; p < 4; p++) do_slot(mode == 3, 1'b1, s);
                for (int f = 0; f < 4; f++) begin
                    pl_a[f] = 24'hA5C3F1 ^ (24'h13579B * (f + 1)) ^ 24'(mode * 7 + k);
                    pr_a[f] = 24'h3C96E7 + (24'h2468AD * (f + 1)) + 24'(mode);
                    cap_left  = 20'hF0E1D ^ (20'h1F3A7 * 20'(f + 1 + mode));
                    cap_right = 20'h5A6B7 + (20'h0C5D3 * 20'(f + 2 + k));
                    nt0 = ntake; nv0 = nvalid;
                    do_half(mode != 3, mode, ns, pl_a[f], cap_left);
                    do_half(mode == 3, mode, ns, pr_a[f], cap_right);
                    check(ntake - nt0 == 1, "R6 take", 40'(ntake - nt0), 40'd1);
                    if (mode == 3) begin
                        check(nvalid - nv0 == 1 && got_l == exp_pb(3, pl_a[f]) &&
                              got_r == exp_pb(3, pr_a[f]), preq,
                              {got_l, got_r}, {exp_pb(3, pl_a[f]), exp_pb(3, pr_a[f])});
                    end else if (f == 0) begin
                        check(nvalid == nv0, "R10 no pair yet", 40'(nvalid - nv0), 40'd0);
                    end else begin
                        check(nvalid - nv0 == 1 && got_l == exp_pb(mode, pl_a[f-1]) &&
                              got_r == exp_pb(mode, pr_a[f-1]), preq,
                              {got_l, got_r},
                              {exp_pb(mode, pl_a[f-1]), exp_pb(mode, pr_a[f-1])});
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog (R1-wide run): actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule